// File: doc/BRIEF.md
# Alternating-Direction Pixel Contrast Sampler

This block watches a raster stream of 8-bit pixels and turns it into a thinned stream of local contrast samples for a difference histogram. It keeps the two previous image rows in internal line memories, so each arriving pixel completes a 3x3 neighbourhood around the pixel one row up and one column back.

For each centre pixel, only one pair of opposite neighbours is compared. On odd centre rows the pair is above and below. On even centre rows it is left and right. The rule flips at every line end. A sample is emitted for every second centre column. The magnitude is clamped to 6 bits, so every strong edge falls into a single top bin while small contrasts keep full resolution.

The stream carries a valid strobe, a start-of-frame flag on the first pixel of a frame and an end-of-line flag on the last pixel of each line. The position of the end-of-line flag sets the line length at run time, up to the MAX_LINE_LEN parameter. Border pixels are never centres, so nothing special is done at the image edges.

Top module: `altdir_diff_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, diff_valid_o is 0 and diff_o is 0.
- R2: When the centre row index is odd, the sample is the absolute difference of the pixels directly above and below the centre. Rows are counted from 0 at the pixel that carries sof_i.
- R3: When the centre row index is even, the sample is the absolute difference of the pixels directly left and right of the centre.
- R4: A sample is produced only when the centre row index is at least 1 and the centre column index is odd (1, 3, 5, ...) and no greater than line length minus 2. Columns count from 0 at the first pixel of a line. So the first and last rows and columns never produce a sample, and no two samples are adjacent in time.
- R5: The magnitude does not depend on which neighbour is larger.
- R6: A magnitude above 63 is output as 63. Values 0 to 63 pass through unchanged.
- R7: diff_o[7:6] are always 0 and diff_o[5:0] carry the magnitude.
- R8: The pixel at centre row+1 and centre column+1 completes a window. diff_valid_o is high for exactly one cycle, two clock cycles after the edge that accepts that pixel.
- R9: Cycles with pix_valid_i low change no state. Inserting idle cycles anywhere in the stream only delays the samples and does not change them.
- R10: A pixel with sof_i high restarts the row count at 0 and the line-parity select at the state for row 0, whatever came before. The pixel with eol_i high ends its line and toggles the line-parity select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel strobe |
| sof_i | input | 1 | First pixel of a frame (qualified by pix_valid_i) |
| eol_i | input | 1 | Last pixel of a line (qualified by pix_valid_i) |
| pix_i | input | 8 | Pixel value |
| diff_valid_o | output | 1 | Sample strobe |
| diff_o | output | 8 | Clamped contrast sample, upper two bits zero |

## Verification
The bench builds the block with MAX_LINE_LEN set to 16, so it can walk every line length from 3 to 16 with frames of three to five rows. That sweep reaches both the even and odd line-length tails of the column rule, and frames run back to back test the row restart. The pixel patterns are chosen arithmetically to land magnitudes at 0, small values, exactly 63, exactly 64 and 255. They also include falling ramps that put the larger neighbour on either side. Some frames carry scattered idle cycles, which tests that the timing shifts while the sample values do not.

// File: rtl/altdir_diff_pkg.sv
package altdir_diff_pkg;
  localparam int unsigned PIX_BITS = 8;
  localparam int unsigned MAG_BITS = 6;
  localparam int unsigned OUT_BITS = 8;

  typedef logic [PIX_BITS-1:0] pix_t;

  typedef enum logic {
    DIR_EW = 1'b0,
    DIR_NS = 1'b1
  } dir_e;

  typedef struct packed {
    pix_t north;
    pix_t south;
    pix_t east;
    pix_t west;
  } taps_t;
endpackage

// File: rtl/altdir_diff_linebuf.sv
module altdir_diff_linebuf
  import altdir_diff_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  pix_t              din_i,
  output pix_t              dout_o
);
  pix_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= din_i;
  end

  // read-before-write: same column of the row above
  assign dout_o = mem_q[addr_i];
endmodule

// File: rtl/altdir_diff_ctrl.sv
module altdir_diff_ctrl
  import altdir_diff_pkg::*;
#(
  parameter int unsigned MAX_LINE_LEN = 1024,
  parameter int unsigned ADDR_W       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic              sof_i,
  input  logic              eol_i,
  output logic [ADDR_W-1:0] col_o,
  output logic              fire_o,
  output dir_e              dir_o
);
  localparam logic [ADDR_W-1:0] COL_LAST = ADDR_W'(MAX_LINE_LEN - 1);
  localparam logic [1:0]        ROW_FULL = 2'd2;

  logic [ADDR_W-1:0] col_q, cur_col;
  logic [1:0]        row_q, cur_row;
  logic              par_q, cur_par;

  always_comb begin
    cur_col = sof_i ? '0   : col_q;
    cur_row = sof_i ? '0   : row_q;
    cur_par = sof_i ? 1'b0 : par_q;
  end

  assign col_o  = cur_col;
  // window complete: two rows above exist, centre column (cur_col-1) is odd
  assign fire_o = (cur_row == ROW_FULL) && (cur_col != '0) && !cur_col[0];
  // incoming row even -> centre row odd -> vertical pair
  assign dir_o  = cur_par ? DIR_EW : DIR_NS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      par_q <= 1'b0;
    end else if (pix_valid_i) begin
      if (eol_i) begin
        col_q <= '0;
        row_q <= (cur_row == ROW_FULL) ? ROW_FULL : cur_row + 2'd1;
        par_q <= ~cur_par;
      end else begin
        col_q <= (cur_col == COL_LAST) ? cur_col : cur_col + 1'b1;
        row_q <= cur_row;
        par_q <= cur_par;
      end
    end
  end
endmodule

// File: rtl/altdir_diff_window.sv
module altdir_diff_window
  import altdir_diff_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  pix_t  bot_i,
  input  pix_t  mid_i,
  input  pix_t  top_i,
  output taps_t taps_o
);
  pix_t row_in [3];
  assign row_in[0] = bot_i;
  assign row_in[1] = mid_i;
  assign row_in[2] = top_i;

  for (genvar r = 0; r < 3; r++) begin : g_row
    // middle row needs both horizontal neighbours, outer rows only the centre
    localparam int unsigned D = (r == 1) ? 3 : 2;
    pix_t q [D];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < int'(D); k++) q[k] <= '0;
      end else if (adv_i) begin
        q[0] <= row_in[r];
        for (int k = 1; k < int'(D); k++) q[k] <= q[k-1];
      end
    end
  end

  assign taps_o.south = g_row[0].q[1];
  assign taps_o.north = g_row[2].q[1];
  assign taps_o.east  = g_row[1].q[0];
  assign taps_o.west  = g_row[1].q[2];
endmodule

// File: rtl/altdir_diff_absclamp.sv
module altdir_diff_absclamp
  import altdir_diff_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  dir_e                dir_i,
  input  taps_t               taps_i,
  output logic                valid_o,
  output logic [OUT_BITS-1:0] diff_o
);
  localparam logic [PIX_BITS-1:0] SAT_LIM = PIX_BITS'((1 << MAG_BITS) - 1);

  pix_t                a, b, mag;
  logic [PIX_BITS:0]   d_ab, d_ba;
  logic [MAG_BITS-1:0] sat;

  always_comb begin
    a    = (dir_i == DIR_NS) ? taps_i.north : taps_i.east;
    b    = (dir_i == DIR_NS) ? taps_i.south : taps_i.west;
    d_ab = {1'b0, a} - {1'b0, b};
    d_ba = {1'b0, b} - {1'b0, a};
    // keep whichever difference did not borrow
    mag  = d_ab[PIX_BITS] ? d_ba[PIX_BITS-1:0] : d_ab[PIX_BITS-1:0];
    sat  = (mag > SAT_LIM) ? SAT_LIM[MAG_BITS-1:0] : mag[MAG_BITS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      diff_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) diff_o <= {{(OUT_BITS-MAG_BITS){1'b0}}, sat};
    end
  end
endmodule

// File: rtl/altdir_diff_gen.sv
module altdir_diff_gen
  import altdir_diff_pkg::*;
#(
  parameter int unsigned MAX_LINE_LEN = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_valid_i,
  input  logic       sof_i,
  input  logic       eol_i,
  input  logic [7:0] pix_i,
  output logic       diff_valid_o,
  output logic [7:0] diff_o
);
  localparam int unsigned ADDR_W = (MAX_LINE_LEN > 1) ? $clog2(MAX_LINE_LEN) : 1;
  localparam int unsigned NUM_LB = 2;

  logic [ADDR_W-1:0] col;
  logic              fire;
  dir_e              dir;
  logic              s1_fire_q;
  dir_e              s1_dir_q;
  taps_t             taps;
  pix_t              lb_in  [NUM_LB];
  pix_t              lb_out [NUM_LB];

  altdir_diff_ctrl #(
    .MAX_LINE_LEN(MAX_LINE_LEN),
    .ADDR_W      (ADDR_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_valid_i(pix_valid_i),
    .sof_i      (sof_i),
    .eol_i      (eol_i),
    .col_o      (col),
    .fire_o     (fire),
    .dir_o      (dir)
  );

  for (genvar i = 0; i < NUM_LB; i++) begin : g_lb
    if (i == 0) begin : g_head
      assign lb_in[i] = pix_i;
    end else begin : g_chain
      assign lb_in[i] = lb_out[i-1];
    end
    altdir_diff_linebuf #(
      .DEPTH (MAX_LINE_LEN),
      .ADDR_W(ADDR_W)
    ) u_lb (
      .clk_i (clk_i),
      .we_i  (pix_valid_i),
      .addr_i(col),
      .din_i (lb_in[i]),
      .dout_o(lb_out[i])
    );
  end

  altdir_diff_window u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (pix_valid_i),
    .bot_i (pix_i),
    .mid_i (lb_out[0]),
    .top_i (lb_out[NUM_LB-1]),
    .taps_o(taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_fire_q <= 1'b0;
      s1_dir_q  <= DIR_EW;
    end else begin
      s1_fire_q <= pix_valid_i && fire;
      if (pix_valid_i) s1_dir_q <= dir;
    end
  end

  altdir_diff_absclamp u_abs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (s1_fire_q),
    .dir_i  (s1_dir_q),
    .taps_i (taps),
    .valid_o(diff_valid_o),
    .diff_o (diff_o)
  );
endmodule

// File: rtl/altdir_diff_chk.sv
module altdir_diff_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pix_valid_i,
  input logic sof_i,
  input logic diff_valid_o
);
  p_pair_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_valid_o |=> !diff_valid_o);

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_valid_o |-> $past(pix_valid_i, 2));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pix_valid_i, 2) |-> !diff_valid_o);

  p_first_row_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pix_valid_i && sof_i, 2) |-> !diff_valid_o);
endmodule

bind altdir_diff_gen altdir_diff_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .sof_i       (sof_i),
  .diff_valid_o(diff_valid_o)
);

// File: tb/altdir_diff_gen_tb_top.sv
`timescale 1ns/1ps
module altdir_diff_gen_tb_top;
  localparam int LEN_MAX = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pix_valid_i = 1'b0;
  logic       sof_i = 1'b0;
  logic       eol_i = 1'b0;
  logic [7:0] pix_i = '0;
  logic       diff_valid_o;
  logic [7:0] diff_o;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  bit    e0_v = 0, e1_v = 0;
  int    e0_d = 0, e1_d = 0;
  string e0_tag = "R8", e1_tag = "R8";

  always #10 clk = ~clk;

  altdir_diff_gen #(.MAX_LINE_LEN(LEN_MAX)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .sof_i       (sof_i),
    .eol_i       (eol_i),
    .pix_i       (pix_i),
    .diff_valid_o(diff_valid_o),
    .diff_o      (diff_o)
  );

  function automatic int pix_at(int p, int r, int c);
    int v;
    case (p)
      0: v = r * 29 + c * c * 7 + c * 13;
      1: v = 100 + r * 3 + c * 2;
      2: v = (((c >> 1) + r) & 1) ? 255 : 0;
      3: v = r * 64 + c;
      4: v = c * 32 + r * 31;
      5: v = (r >> 1) * 63 + c;
      default: v = 255 - r * 20 - c * 9;
    endcase
    return v & 255;
  endfunction

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic step(bit pv, bit sof, bit eol, int px, bit ev, int ed, string tag);
    @(negedge clk);
    checks++;
    if (diff_valid_o !== e1_v) begin
      fails++;
      $display("FAIL %s valid act=%0b exp=%0b", e1_tag, diff_valid_o, e1_v);
    end
    if (e1_v && diff_valid_o === 1'b1) begin
      checks++;
      if (diff_o !== 8'(e1_d)) begin
        fails++;
        $display("FAIL %s data act=%0d exp=%0d", e1_tag, diff_o, e1_d);
      end
      checks++;
      if (diff_o[7:6] !== 2'b00) begin
        fails++;
        $display("FAIL R7 upper bits act=%0b exp=00", diff_o[7:6]);
      end
    end
    e1_v = e0_v; e1_d = e0_d; e1_tag = e0_tag;
    e0_v = ev;   e0_d = ed;   e0_tag = tag;
    pix_valid_i = pv; sof_i = sof; eol_i = eol; pix_i = 8'(px);
  endtask

  task automatic run_frame(int p, int len, int h, bit gaps);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < len; c++) begin
        bit    ev;
        bit    ns;
        int    raw;
        int    ed;
        string tag;
        if (gaps && (((r * 16 + c) * 5 + p) % 7 == 0))
          step(0, 0, 0, 8'hA5, 0, 0, "R9");
        ev  = (r >= 2) && (c >= 2) && (c % 2 == 0);
        ns  = ((r - 1) % 2) != 0;
        raw = 0;
        if (ev) raw = ns ? iabs(pix_at(p, r - 2, c - 1) - pix_at(p, r, c - 1))
                         : iabs(pix_at(p, r - 1, c) - pix_at(p, r - 1, c - 2));
        ed  = (raw > 63) ? 63 : raw;
        if (ev) tag = (raw > 63) ? "R6" : (p == 6) ? "R5" : ns ? "R2" : "R3";
        else    tag = (r < 2) ? "R10 R4" : "R4 R8";
        if (gaps) tag = {tag, " R9"};
        step(1, (r == 0 && c == 0), (c == len - 1), pix_at(p, r, c), ev, ed, tag);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (diff_valid_o !== 1'b0 || diff_o !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset act=%0b/%0d exp=0/0", diff_valid_o, diff_o);
    end
    for (int len = 3; len <= LEN_MAX; len++) begin
      for (int p = 0; p < 7; p++) begin
        run_frame(p, len, 3 + (len % 3), (len % 2) == 1);
        if (p == 3) begin
          step(0, 0, 0, 0, 0, 0, "R9");
          step(0, 0, 0, 0, 0, 0, "R9");
        end
      end
    end
    repeat (3) step(0, 0, 0, 0, 0, 0, "R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule